// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Burner

This controller burns one 32-bit word of a one-time-programmable fuse array for each software request. Software reaches it through three registers on a simple register port: a control register, a timing register and a data register. The control register carries the target word address, the status flags and a 16-bit unlock field. The timing register carries three cycle counts. The data register takes the word to be burned. A burn is accepted only when the unlock field holds the key and the data register is then written.

After a burn is accepted, the controller latches the address. It reads the current contents of the fuse word and clears every bit that is already blown from the pending data. It then walks the 32 bit positions from bit 0 upward, using a bit-serial program port. Each position that still needs programming gets a strobe of fixed length followed by a relax gap. Positions that need no programming take one cycle each and get no strobe. After the last position, a quiet period follows, and BUSY stays high until it ends. A word flagged as locked by the array is never touched. The request instead raises ERROR, and ERROR refuses further burns until software clears it.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset, the control, timing and data registers read as zero and the strobe is low.
- R2: Control register (select 0) layout: address in bits 7:0, BUSY in bit 8, ERROR in bit 9, bit 10 reserved and reading 0, unlock field in bits 31:16. Bus writes to bits 8, 9 and 10 never set those bits.
- R3: A data-register write (select 2) starts a burn only if the unlock field equals 16'h3E77. With any other value the write causes no BUSY and no strobe.
- R4: Any data-register write while not busy clears the unlock field. A second burn therefore needs the key written again.
- R5: The word burned is the written data with already-blown fuse bits removed. The strobe count equals the number of 1 bits in (data AND NOT fuse word), and afterwards the fuse word equals old OR data.
- R6: The address is captured when a burn is accepted. Writes to the address field during BUSY do not change the word being burned.
- R7: The data register shifts right with zero fill as positions are consumed, so it reads 0 once the burn ends. Bus writes to it during BUSY are ignored.
- R8: A burn request to a word that the array reports as locked does not set BUSY and does not touch the array. It sets ERROR instead.
- R9: While ERROR is set, burn requests are refused. Writing a 1 to control bit 9 clears ERROR.
- R10: Timing register (select 1): strobe-program count in bits 11:0, relax count in bits 15:12, strobe-read count in bits 21:16, other bits reading 0. Each strobe lasts max(1, program + relax) cycles.
- R11: BUSY lasts (read + 1) + 32 + n × (strobe length + relax) + P cycles, where n is the number of strobed bits and P is the quiet period in cycles. P is ceil(POST_NS × CLK_MHZ / 1000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 timing, 2 data |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| fuse_addr | output | ADDR_W | Word address for the array read and program ports |
| fuse_rdata | input | 32 | Current contents of the addressed fuse word |
| fuse_lock | input | 1 | Addressed fuse word is locked |
| prog_strobe | output | 1 | Program strobe for one bit |
| prog_bit | output | 1 | Serial program data bit, valid with the strobe |
| prog_bitpos | output | 5 | Bit position being programmed |

## Verification
The bench builds the block at its 250 MHz default with POST_NS set to 48, which gives a 12-cycle quiet period. At that length the full BUSY duration formula can be checked exactly on every burn, with no long waits. The vector table sweeps the timing fields through small values, including zero program and zero relax counts, so both the one-cycle minimum strobe and the skipped relax gap are reached. A strobe-read count of 40 keeps the block in its read phase long enough to write the address field and the data register during BUSY and confirm that both writes are ignored.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_TIME = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  typedef struct packed {
    logic [5:0]  rd;
    logic [3:0]  relax;
    logic [11:0] sp;
  } timing_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_SCAN,
    S_STRB,
    S_GAP,
    S_POST
  } burn_state_t;

endpackage

// File: rtl/otp_ctrl_regs.sv
module otp_ctrl_regs
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              we,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              fuse_lock,
  output logic [ADDR_W-1:0] ctrl_addr,
  output logic [15:0]       unlock_q,
  output logic              err_q,
  output timing_t           timing_q,
  output logic              start
);

  logic              wr_ctrl, wr_time, wr_data, armed, accept, lock_hit;
  logic [ADDR_W-1:0] addr_d;
  logic [15:0]       unlock_d;
  logic              err_d;
  timing_t           timing_d;
  logic              unused_bits;

  assign unused_bits = ^{wdata[31:22], wdata[15:10], wdata[8]};

  assign wr_ctrl  = we && (sel == SEL_CTRL);
  assign wr_time  = we && (sel == SEL_TIME);
  assign wr_data  = we && (sel == SEL_DATA);
  assign armed    = (unlock_q == UNLOCK_KEY);
  assign accept   = wr_data && armed && !busy && !err_q;
  assign start    = accept && !fuse_lock;
  assign lock_hit = accept && fuse_lock;

  always_comb begin
    addr_d   = ctrl_addr;
    unlock_d = unlock_q;
    err_d    = err_q;
    timing_d = timing_q;
    if (wr_ctrl) begin
      addr_d   = wdata[ADDR_W-1:0];
      unlock_d = wdata[31:16];
      if (wdata[9]) err_d = 1'b0;
    end
    if (wr_time) timing_d = wdata[21:0];
    if (wr_data && !busy) unlock_d = '0;
    if (lock_hit) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_addr <= '0;
      unlock_q  <= '0;
      err_q     <= 1'b0;
      timing_q  <= '0;
    end else begin
      if (wr_ctrl || wr_data || lock_hit) begin
        ctrl_addr <= addr_d;
        unlock_q  <= unlock_d;
        err_q     <= err_d;
      end
      if (wr_time) timing_q <= timing_d;
    end
  end

  // R8: a locked request never raises BUSY together with ERROR
  p_lock_no_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !busy);

  // R4: an accepted burn leaves the block disarmed
  p_start_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (unlock_q != UNLOCK_KEY));

endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DW          = 32,
  parameter int POST_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DW-1:0]     wdata,
  input  timing_t           timing,
  input  logic [DW-1:0]     fuse_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DW-1:0]     data_q,
  output logic [$clog2(DW)-1:0] bitpos,
  output logic              strobe,
  output logic              pbit
);

  localparam int BW    = $clog2(DW);
  localparam int PW    = $clog2(POST_CYCLES + 1);
  localparam int CNT_W = (PW > 13) ? PW : 13;
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  burn_state_t       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, strb_len, relax_len;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DW-1:0]     data_d;
  logic [ADDR_W-1:0] addr_d;
  logic              adv;

  assign strb_len  = CNT_W'(timing.sp) + CNT_W'(timing.relax);
  assign relax_len = CNT_W'(timing.relax);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    data_d = data_q;
    addr_d = addr_q;
    adv    = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        st_d   = S_READ;
        cnt_d  = '0;
        data_d = wdata;
        addr_d = addr_in;
      end
      S_READ: if (cnt_q == CNT_W'(timing.rd)) begin
        st_d   = S_SCAN;
        cnt_d  = '0;
        bit_d  = '0;
        data_d = data_q & ~fuse_rdata;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
      S_SCAN: if (data_q[0]) begin
        st_d  = S_STRB;
        cnt_d = '0;
      end else begin
        adv = 1'b1;
      end
      S_STRB: if ((cnt_q + CNT_W'(1)) >= strb_len) begin
        cnt_d = '0;
        if (timing.relax == '0) adv = 1'b1;
        else st_d = S_GAP;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
      S_GAP: if ((cnt_q + CNT_W'(1)) >= relax_len) adv = 1'b1;
             else cnt_d = cnt_q + CNT_W'(1);
      S_POST: if (cnt_q == CNT_W'(POST_CYCLES - 1)) st_d = S_IDLE;
              else cnt_d = cnt_q + CNT_W'(1);
      default: st_d = S_IDLE;
    endcase
    if (adv) begin
      data_d = data_q >> 1;
      cnt_d  = '0;
      if (bit_q == LAST_BIT) begin
        st_d = S_POST;
      end else begin
        st_d  = S_SCAN;
        bit_d = bit_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      data_q <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      data_q <= data_d;
      if (st_q == S_IDLE) addr_q <= addr_d;
    end
  end

  assign busy   = (st_q != S_IDLE);
  assign strobe = (st_q == S_STRB);
  assign pbit   = strobe & data_q[0];
  assign bitpos = bit_q;

  // R5: a strobe is only ever issued for a position that still holds a 1
  p_strobe_on_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> data_q[0]);

  // R6: the latched address holds for the whole burn
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));

  // R7: all positions are consumed before the quiet period
  p_post_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_POST) |-> (data_q == '0));

  // R11: leaving the quiet period only after its full length
  p_post_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_POST && st_q == S_IDLE) |-> ($past(cnt_q) == CNT_W'(POST_CYCLES - 1)));

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CLK_MHZ = 250,
  parameter int POST_NS = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [ADDR_W-1:0] fuse_addr,
  input  logic [31:0]       fuse_rdata,
  input  logic              fuse_lock,
  output logic              prog_strobe,
  output logic              prog_bit,
  output logic [4:0]        prog_bitpos
);

  localparam int POST_CYCLES = (POST_NS * CLK_MHZ + 999) / 1000;

  logic              rst_meta, rst_sync;
  logic [ADDR_W-1:0] ctrl_addr, addr_q;
  logic [15:0]       unlock_q;
  logic              err_q, busy, start;
  timing_t           timing_q;
  logic [31:0]       data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  otp_ctrl_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync),
    .sel       (reg_sel),
    .we        (reg_we),
    .wdata     (reg_wdata),
    .busy      (busy),
    .fuse_lock (fuse_lock),
    .ctrl_addr (ctrl_addr),
    .unlock_q  (unlock_q),
    .err_q     (err_q),
    .timing_q  (timing_q),
    .start     (start)
  );

  otp_burn_seq #(.ADDR_W(ADDR_W), .DW(32), .POST_CYCLES(POST_CYCLES)) seq_i (
    .clk        (clk),
    .rst_n      (rst_sync),
    .start      (start),
    .addr_in    (ctrl_addr),
    .wdata      (reg_wdata),
    .timing     (timing_q),
    .fuse_rdata (fuse_rdata),
    .busy       (busy),
    .addr_q     (addr_q),
    .data_q     (data_q),
    .bitpos     (prog_bitpos),
    .strobe     (prog_strobe),
    .pbit       (prog_bit)
  );

  assign fuse_addr = busy ? addr_q : ctrl_addr;

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = {unlock_q, 5'b0, 1'b0, err_q, busy, 8'(ctrl_addr)};
      SEL_TIME: reg_rdata = {10'b0, timing_q};
      SEL_DATA: reg_rdata = data_q;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: tb/otp_prog_ctrl_tb_top.sv
module otp_prog_ctrl_tb_top;

  localparam int POSTC = 12;
  localparam logic [15:0] KEY = 16'h3E77;

  localparam logic [7:0]  V_ADDR [4] = '{8'h10, 8'h20, 8'h30, 8'hFF};
  localparam logic [31:0] V_OLD  [4] = '{32'h0000_00F0, 32'h0, 32'hFFFF_0000, 32'h1234_5678};
  localparam logic [31:0] V_DATA [4] = '{32'h8000_00FF, 32'h1, 32'hFFFF_0000, 32'hA5A5_A5A5};
  localparam logic [11:0] V_SP   [4] = '{12'd3, 12'd7, 12'd1, 12'd0};
  localparam logic [3:0]  V_RLX  [4] = '{4'd2, 4'd0, 4'd1, 4'd0};
  localparam logic [5:0]  V_RD   [4] = '{6'd0, 6'd4, 6'd2, 6'd1};

  logic        clk, rst_n, reg_we, fuse_lock, prog_strobe, prog_bit;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata, fuse_rdata;
  logic [7:0]  fuse_addr;
  logic [4:0]  prog_bitpos;

  logic [31:0] fz [256];
  logic        lk [256];

  int checks, errors, pulses, bad_len, run, exp_len;
  bit finished;

  otp_prog_ctrl #(.ADDR_W(8), .CLK_MHZ(250), .POST_NS(48)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fuse_addr(fuse_addr),
    .fuse_rdata(fuse_rdata), .fuse_lock(fuse_lock), .prog_strobe(prog_strobe),
    .prog_bit(prog_bit), .prog_bitpos(prog_bitpos)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign fuse_rdata = fz[fuse_addr];
  assign fuse_lock  = lk[fuse_addr];

  always @(negedge clk) begin
    if (prog_strobe) begin
      run = run + 1;
      if (prog_bit) fz[fuse_addr][prog_bitpos] = 1'b1;
    end else if (run > 0) begin
      pulses = pulses + 1;
      if (run != exp_len) bad_len = bad_len + 1;
      run = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    reg_sel = s; reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'd0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    rd(2'd0, v);
    while (v[8]) begin
      cyc = cyc + 1;
      rd(2'd0, v);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cyc, n, tl, p0;
    checks = 0; errors = 0; pulses = 0; bad_len = 0; run = 0; exp_len = 1;
    finished = 0;
    for (int i = 0; i < 256; i++) begin fz[i] = '0; lk[i] = 1'b0; end
    reg_sel = 2'd0; reg_we = 1'b0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(2'd1, v); chk("R1 timing", v, 32'h0);
    rd(2'd2, v); chk("R1 data", v, 32'h0);
    chk("R1 strobe", {31'b0, prog_strobe}, 32'h0);

    // R2: control layout, status bits not writable
    wr(2'd0, 32'h1234_075A);
    rd(2'd0, v); chk("R2 ctrl readback", v, 32'h1234_005A);
    // R10: timing layout
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R10 timing readback", v, 32'h003F_FFFF);

    // vector table walk (R5, R10, R11, R4, R7)
    for (int k = 0; k < 4; k++) begin
      fz[V_ADDR[k]] = V_OLD[k];
      wr(2'd1, {10'b0, V_RD[k], V_RLX[k], V_SP[k]});
      tl = int'(V_SP[k]) + int'(V_RLX[k]);
      if (tl < 1) tl = 1;
      exp_len = tl;
      n = $countones(V_DATA[k] & ~V_OLD[k]);
      p0 = pulses; bad_len = 0;
      wr(2'd0, {KEY, 8'h00, V_ADDR[k]});
      wr(2'd2, V_DATA[k]);
      wait_idle(cyc);
      cyc = cyc + 1;
      repeat (2) @(negedge clk);
      chk("R11 busy length", cyc, int'(V_RD[k]) + 1 + 32 + n * (tl + int'(V_RLX[k])) + POSTC);
      chk("R5 strobe count", pulses - p0, n);
      chk("R5 fuse result", fz[V_ADDR[k]], V_OLD[k] | V_DATA[k]);
      chk("R10 strobe width", bad_len, 0);
      rd(2'd0, v); chk("R4 unlock cleared", v[31:16], 16'h0);
      rd(2'd2, v); chk("R7 data drained", v, 32'h0);
    end

    // R3: wrong key does not start
    p0 = pulses;
    wr(2'd0, 32'h3E76_0050);
    wr(2'd2, 32'h0000_00FF);
    rd(2'd0, v); chk("R3 no busy", v[8], 1'b0);
    repeat (5) @(negedge clk);
    chk("R3 fuse untouched", fz[8'h50], 32'h0);
    chk("R3 no strobe", pulses - p0, 0);

    // R4: second burn needs a fresh key
    wr(2'd1, {10'b0, 6'd0, 4'd1, 12'd1});
    wr(2'd0, {KEY, 16'h0051});
    wr(2'd2, 32'h0000_000F);
    wait_idle(cyc);
    wr(2'd2, 32'h0000_00F0);
    rd(2'd0, v); chk("R4 rearm needed", v[8], 1'b0);
    repeat (5) @(negedge clk);
    chk("R4 fuse kept", fz[8'h51], 32'h0000_000F);

    // R6, R7: writes during BUSY ignored
    wr(2'd1, {10'b0, 6'd40, 4'd1, 12'd2});
    wr(2'd0, {KEY, 16'h0040});
    wr(2'd2, 32'h0000_0F0F);
    rd(2'd2, v); chk("R7 data held in read phase", v, 32'h0000_0F0F);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R7 write during busy ignored", v, 32'h0000_0F0F);
    wr(2'd0, 32'h0000_0041);
    wait_idle(cyc);
    chk("R6 burned latched word", fz[8'h40], 32'h0000_0F0F);
    chk("R6 other word untouched", fz[8'h41], 32'h0);

    // R8: locked word
    lk[8'h60] = 1'b1;
    fz[8'h60] = 32'h0000_0001;
    p0 = pulses;
    wr(2'd0, {KEY, 16'h0060});
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd0, v);
    chk("R8 no busy", v[8], 1'b0);
    chk("R8 error set", v[9], 1'b1);
    repeat (5) @(negedge clk);
    chk("R8 fuse untouched", fz[8'h60], 32'h0000_0001);
    chk("R8 no strobe", pulses - p0, 0);

    // R9: error blocks until cleared
    wr(2'd0, {KEY, 16'h0061});
    wr(2'd2, 32'h0000_0003);
    rd(2'd0, v); chk("R9 refused while error", v[8], 1'b0);
    repeat (5) @(negedge clk);
    chk("R9 fuse untouched", fz[8'h61], 32'h0);
    wr(2'd0, {KEY, 16'h0261});
    rd(2'd0, v); chk("R9 error cleared", v[9], 1'b0);
    wr(2'd2, 32'h0000_0003);
    rd(2'd0, v); chk("R9 accepted after clear", v[8], 1'b1);
    wait_idle(cyc);
    chk("R9 fuse burned", fz[8'h61], 32'h0000_0003);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule